// File: doc/BRIEF.md
# DFI Write-Enable Phase Encoder

This block sits in a memory controller whose DFI clock runs at one half or one quarter of the DRAM clock. Each DFI clock is split into two or four phase lanes. When the controller accepts a write command, the block works out in which later DFI clock, and on which phase lane, the PHY must start taking write data. It then drives the per-lane write-data-enable outputs over the right number of consecutive lane slots. When the last lane of a DFI clock is used up, the window carries on from lane 0 of the next clock. The phase of the data window is therefore carried only by which lane enables are high.

The slot position is P = command phase + write latency, counted in DRAM clocks. Because the latency need not be a multiple of the ratio, a window can start part way through a DFI clock and spread over two or more of them. Each command's window is written into a per-lane delay line. Windows from back-to-back commands merge by OR. The ratio, latency and burst length that a command uses are taken from the configuration inputs only while no window is pending or queued.

Top module: `dfi_wren_phase_enc`

## Requirements
- R1: After reset, and until a command is accepted, all four bits of `wrdata_en` are low.
- R2: With lane count L (L=2 when `cfg_ratio4`=0, L=4 when `cfg_ratio4`=1) and P = effective phase + write latency, the first enabled slot is lane P mod L in the DFI clock floor(P/L)+1 cycles after the cycle in which `cmd_valid` is high. Bit i of `wrdata_en` is lane i.
- R3: Each later slot uses the next lane up. After lane L-1 the window continues on lane 0 of the following DFI clock, with no idle slot in between.
- R4: A window spans 4 slots when `cfg_bl16`=0 (burst of 8) and 8 slots when `cfg_bl16`=1 (burst of 16), in both ratios.
- R5: In 1:2 mode, lanes 2 and 3 stay low and bit 1 of `cmd_phase` is ignored.
- R6: In 1:2 mode with an odd write latency W and a command on lane 0, lane 1 rises floor(W/2)+1 cycles after the command cycle and lane 0 rises one cycle after that.
- R7: Windows of commands issued in successive cycles are merged by OR, and each keeps its own position.
- R8: The configuration is taken from the inputs in any cycle in which no enable is pending or queued. While an enable is pending, the configuration held from the last such cycle is used, and changes at the inputs have no effect.
- R9: Write latencies from 0 up to MAX_WL (24 by default) are supported, including the largest latency combined with the highest phase and a burst of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write command accepted in this cycle |
| cmd_phase | input | 2 | Phase lane the command occupies |
| cfg_ratio4 | input | 1 | 0: 1:2 ratio, 1: 1:4 ratio |
| cfg_wrlat | input | 5 | Write latency in DRAM clocks (0..MAX_WL) |
| cfg_bl16 | input | 1 | 0: burst of 8, 1: burst of 16 |
| wrdata_en | output | 4 | Per-lane write-data enables, bit i is lane i |

## Verification
The bench goes after windows that cross a DFI clock boundary: odd latencies in 1:2 mode, and phase 3 in 1:4 mode. A design that mishandles the wrap would start lane 0 in the same cycle as the last lane, or drop the slot altogether. In 1:2 mode it drives phase values whose upper bit is set, to catch a design that lets a 1:4-style lane leak onto lanes 2 and 3. It issues commands back to back, so a design that overwrites the delay line instead of ORing into it loses one window. It also changes the latency while a window is pending, so a design that reads the live inputs places the second window at the wrong slot. The largest latency with a burst of 16 exposes a delay line one stage too short, which would cut off the end of the window.

// File: rtl/dfi_wen_pkg.sv
package dfi_wen_pkg;

   typedef enum logic {
      RATIO_2 = 1'b0,
      RATIO_4 = 1'b1
   } ratio_e;

   localparam int LANE_CNT = 4;

   // True when absolute slot s falls inside [lo, lo+cnt)
   function automatic logic slot_hit(int s, int lo, int cnt);
      return (s >= lo) && (s < lo + cnt);
   endfunction

endpackage

// File: rtl/dfi_wen_cfg.sv
module dfi_wen_cfg
   import dfi_wen_pkg::*;
#(
   parameter int WL_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            idle,
   input  ratio_e          ratio_in,
   input  logic [WL_W-1:0] wl_in,
   input  logic            bl16_in,
   output ratio_e          ratio_eff,
   output logic [WL_W-1:0] wl_eff,
   output logic            bl16_eff
);

   ratio_e          ratio_q;
   logic [WL_W-1:0] wl_q;
   logic            bl16_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ratio_q <= RATIO_2;
         wl_q    <= '0;
         bl16_q  <= 1'b0;
      end else if (idle) begin
         ratio_q <= ratio_in;
         wl_q    <= wl_in;
         bl16_q  <= bl16_in;
      end
   end

   assign ratio_eff = idle ? ratio_in : ratio_q;
   assign wl_eff    = idle ? wl_in    : wl_q;
   assign bl16_eff  = idle ? bl16_in  : bl16_q;

   // R8: across two busy cycles in a row the configuration in use cannot move
   p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && !$past(idle)) |-> $stable({ratio_eff, wl_eff, bl16_eff}));

endmodule

// File: rtl/dfi_wen_mask.sv
module dfi_wen_mask
   import dfi_wen_pkg::*;
#(
   parameter int LANES        = 4,
   parameter int DEPTH        = 17,
   parameter int WL_W         = 5,
   parameter bit SUPPORT_BL16 = 1'b1
) (
   input  ratio_e                        ratio,
   input  logic [1:0]                    phase,
   input  logic [WL_W-1:0]               wl,
   input  logic                          bl16,
   output logic [DEPTH-1:0][LANES-1:0]   mask
);

   localparam int PW = WL_W + 2;

   logic [1:0]    ph_eff;
   logic [PW-1:0] start_pos;
   logic [3:0]    nslots;

   // 1:2 mode only knows lanes 0 and 1
   assign ph_eff    = (ratio == RATIO_4) ? phase : {1'b0, phase[0]};
   assign start_pos = PW'(ph_eff) + PW'(wl);

   generate
      if (SUPPORT_BL16) begin : g_bl16
         assign nslots = bl16 ? 4'd8 : 4'd4;
      end else begin : g_bl8
         assign nslots = 4'd4;
      end
   endgenerate

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cyc
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam int SLOT2 = i * 2 + l;
            localparam int SLOT4 = i * 4 + l;
            if (l < 2) begin : g_shared
               assign mask[i][l] = (ratio == RATIO_4)
                  ? slot_hit(SLOT4, int'(start_pos), int'(nslots))
                  : slot_hit(SLOT2, int'(start_pos), int'(nslots));
            end else begin : g_quad
               assign mask[i][l] = (ratio == RATIO_4)
                  && slot_hit(SLOT4, int'(start_pos), int'(nslots));
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dfi_wen_sched.sv
module dfi_wen_sched #(
   parameter int LANES = 4,
   parameter int DEPTH = 17
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ins_en,
   input  logic [DEPTH-1:0][LANES-1:0] ins_mask,
   output logic [LANES-1:0]            en,
   output logic                        idle
);

   logic [DEPTH-1:0][LANES-1:0] q;
   logic [DEPTH-1:0][LANES-1:0] shifted;
   logic [DEPTH-1:0][LANES-1:0] added;

   assign shifted = {{LANES{1'b0}}, q[DEPTH-1:1]};
   assign added   = ins_en ? ins_mask : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= shifted | added;
   end

   assign en   = q[0];
   assign idle = (q == '0);

   // R2: with nothing queued and nothing inserted, no enable may appear
   p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !ins_en) |=> (en == '0));

endmodule

// File: rtl/dfi_wren_phase_enc.sv
module dfi_wren_phase_enc
   import dfi_wen_pkg::*;
#(
   parameter int MAX_WL       = 24,
   parameter bit SUPPORT_BL16 = 1'b1,
   parameter int LANES        = 4,
   localparam int WL_W        = $clog2(MAX_WL + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [1:0]      cmd_phase,
   input  logic            cfg_ratio4,
   input  logic [WL_W-1:0] cfg_wrlat,
   input  logic            cfg_bl16,
   output logic [LANES-1:0] wrdata_en
);

   localparam int MAX_SLOTS = SUPPORT_BL16 ? 8 : 4;
   // worst case is 1:2 with phase 1, largest latency and longest burst
   localparam int DEPTH     = (1 + MAX_WL + MAX_SLOTS - 1) / 2 + 1;

   generate
      if (LANES != LANE_CNT) begin : g_bad_lanes
         $error("LANES must equal 4");
      end
      if (MAX_WL < 1) begin : g_bad_wl
         $error("MAX_WL must be at least 1");
      end
   endgenerate

   logic                        idle;
   ratio_e                      ratio_eff;
   logic [WL_W-1:0]             wl_eff;
   logic                        bl16_eff;
   logic [DEPTH-1:0][LANES-1:0] ins_mask;

   dfi_wen_cfg #(.WL_W(WL_W)) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .idle      (idle),
      .ratio_in  (ratio_e'(cfg_ratio4)),
      .wl_in     (cfg_wrlat),
      .bl16_in   (cfg_bl16),
      .ratio_eff (ratio_eff),
      .wl_eff    (wl_eff),
      .bl16_eff  (bl16_eff)
   );

   dfi_wen_mask #(
      .LANES(LANES), .DEPTH(DEPTH), .WL_W(WL_W), .SUPPORT_BL16(SUPPORT_BL16)
   ) i_mask (
      .ratio (ratio_eff),
      .phase (cmd_phase),
      .wl    (wl_eff),
      .bl16  (bl16_eff),
      .mask  (ins_mask)
   );

   dfi_wen_sched #(.LANES(LANES), .DEPTH(DEPTH)) i_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .ins_en   (cmd_valid),
      .ins_mask (ins_mask),
      .en       (wrdata_en),
      .idle     (idle)
   );

   // R5: upper lanes are silent whenever 1:2 is the ratio in force
   p_hi_lanes_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_eff == RATIO_2) |-> (wrdata_en[3:2] == 2'b00));

   // R4: a command inserts exactly one burst worth of slots
   p_slot_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> ($countones(ins_mask) == ((SUPPORT_BL16 && bl16_eff) ? 8 : 4)));

   // R9: latency in range when a command is accepted
   p_wl_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (int'(cfg_wrlat) <= MAX_WL));

endmodule

// File: tb/test_dfi_wren_phase_enc.sv
`timescale 1ns/1ps
module test_dfi_wren_phase_enc;

   localparam int MAX_WL = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_phase = 2'd0;
   logic       cfg_ratio4 = 1'b0;
   logic [4:0] cfg_wrlat = 5'd0;
   logic       cfg_bl16 = 1'b0;
   logic [3:0] wrdata_en;

   always #2.5 clk = ~clk;

   dfi_wren_phase_enc i_dfi_wren_phase_enc (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_phase(cmd_phase),
      .cfg_ratio4(cfg_ratio4), .cfg_wrlat(cfg_wrlat), .cfg_bl16(cfg_bl16),
      .wrdata_en(wrdata_en)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [3:0] expv [0:4095];
   int  checks = 0;
   int  fails = 0;
   bit  done = 1'b0;

   // live configuration driven by the tests, and the model's held copy
   bit  lv_r4 = 1'b0;
   int  lv_wl = 0;
   bit  lv_bl16 = 1'b0;
   bit  m_r4 = 1'b0;
   int  m_wl = 0;
   bit  m_bl16 = 1'b0;

   task automatic cmp(string tag, logic [3:0] want);
      checks++;
      if (wrdata_en !== want) begin
         fails++;
         $display("FAIL %s cycle=%0d wrdata_en=%b expected=%b", tag, cyc, wrdata_en, want);
      end
   endtask

   // one DFI cycle: check this cycle's output, then drive the next inputs
   task automatic step(bit v, int ph, string tag);
      bit idle_m;
      @(negedge clk);
      cmp(tag, expv[cyc]);
      idle_m = 1'b1;
      for (int j = 0; j < 40; j++) if (expv[cyc + j] != 4'd0) idle_m = 1'b0;
      if (idle_m) begin
         m_r4 = lv_r4; m_wl = lv_wl; m_bl16 = lv_bl16;
      end
      cmd_valid  = v;
      cmd_phase  = 2'(ph);
      cfg_ratio4 = lv_r4;
      cfg_wrlat  = 5'(lv_wl);
      cfg_bl16   = lv_bl16;
      if (v) begin
         int lanes, p, n;
         lanes = m_r4 ? 4 : 2;
         p = (ph % lanes) + m_wl;
         n = m_bl16 ? 8 : 4;
         for (int k = 0; k < n; k++) begin
            int s;
            s = p + k;
            expv[cyc + 1 + s / lanes][s % lanes] = 1'b1;
         end
      end
   endtask

   task automatic quiet(int n, string tag);
      for (int i = 0; i < n; i++) step(1'b0, 0, tag);
   endtask

   task automatic t_reset();
      quiet(4, "R1");
   endtask

   task automatic t_sweep();
      for (int r = 0; r < 2; r++)
         for (int ph = 0; ph < 4; ph++)
            for (int w = 4; w < 8; w++) begin
               lv_r4 = bit'(r); lv_wl = w; lv_bl16 = 1'b0;
               quiet(1, "R2");
               step(1'b1, ph, "R2");
               quiet(12, "R2");
            end
   endtask

   task automatic t_wrap4();
      lv_r4 = 1'b1; lv_wl = 2; lv_bl16 = 1'b0;
      quiet(1, "R3");
      step(1'b1, 3, "R3");     // P=5: cycle+2 lanes 1..3, cycle+3 lane 0
      step(1'b0, 0, "R3");
      step(1'b0, 0, "R3");
      cmp("R3", 4'b1110);
      step(1'b0, 0, "R3");
      cmp("R3", 4'b0001);
      quiet(4, "R3");
   endtask

   task automatic t_bl16();
      for (int r = 0; r < 2; r++)
         for (int ph = 0; ph < 4; ph++) begin
            lv_r4 = bit'(r); lv_wl = 3 + ph; lv_bl16 = 1'b1;
            quiet(1, "R4");
            step(1'b1, ph, "R4");
            quiet(12, "R4");
         end
   endtask

   task automatic t_phase_hi();
      lv_r4 = 1'b0; lv_wl = 4; lv_bl16 = 1'b0;
      quiet(1, "R5");
      step(1'b1, 3, "R5");     // treated as lane 1: P=5
      quiet(2, "R5");
      step(1'b0, 0, "R5");
      cmp("R5", 4'b0010);
      quiet(6, "R5");
   endtask

   task automatic t_odd_wl();
      lv_r4 = 1'b0; lv_wl = 5; lv_bl16 = 1'b0;
      quiet(1, "R6");
      step(1'b1, 0, "R6");     // P=5: lane 1 at +3, lanes 0,1 at +4, lane 0 at +5
      quiet(2, "R6");
      step(1'b0, 0, "R6");
      cmp("R6", 4'b0010);
      step(1'b0, 0, "R6");
      cmp("R6", 4'b0011);
      step(1'b0, 0, "R6");
      cmp("R6", 4'b0001);
      quiet(4, "R6");
   endtask

   task automatic t_overlap();
      lv_r4 = 1'b1; lv_wl = 6; lv_bl16 = 1'b0;
      quiet(1, "R7");
      step(1'b1, 0, "R7");
      step(1'b1, 2, "R7");
      step(1'b1, 1, "R7");
      step(1'b1, 3, "R7");
      quiet(10, "R7");
      lv_r4 = 1'b0; lv_wl = 7; lv_bl16 = 1'b1;
      step(1'b1, 0, "R7");
      step(1'b1, 1, "R7");
      quiet(14, "R7");
   endtask

   task automatic t_cfg_hold();
      lv_r4 = 1'b0; lv_wl = 8; lv_bl16 = 1'b0;
      quiet(1, "R8");
      step(1'b1, 0, "R8");
      lv_wl = 3; lv_r4 = 1'b1; lv_bl16 = 1'b1;   // must be ignored while pending
      step(1'b1, 1, "R8");
      quiet(14, "R8");
      step(1'b1, 1, "R8");                       // now idle: new settings apply
      quiet(8, "R8");
   endtask

   task automatic t_max_wl();
      lv_r4 = 1'b0; lv_wl = MAX_WL; lv_bl16 = 1'b1;
      quiet(1, "R9");
      step(1'b1, 1, "R9");
      quiet(20, "R9");
      lv_r4 = 1'b1;
      step(1'b1, 3, "R9");
      quiet(12, "R9");
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) expv[i] = 4'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sweep();
      t_wrap4();
      t_bl16();
      t_phase_hi();
      t_odd_wl();
      t_overlap();
      t_cfg_hold();
      t_max_wl();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule